// File: doc/BRIEF.md
# DMA Burst Request Handshake Controller

This block is the device-facing burst control of one DMA channel. It runs the bus state sequence for each access to a peripheral, raises a device acknowledge strobe with address-strobe timing, and samples the peripheral's request line late in every device access. The sampled request decides whether the burst goes on, pauses, or resumes later. The request can be taken straight from the pin or through a one-flop synchronizer, which moves the deadline for a negation one clock earlier.

Fast-terminating device accesses are handled with a one-cycle stop delay. The controller can also pack bytes between a 32-bit memory and an 8-bit peripheral through a four-lane holding register. In that mode a lane counter walks the bytes. When the peripheral is the source and the burst stops, a partly filled holding register is written to memory, with byte enables, before the controller goes idle.

Top module: `dmab_burst_ctrl`

## Requirements
- R1: After reset the controller is idle: `bus_state`=0, no strobe is high, `mem_be`=0 and `lane`=0.
- R2: `dack` is high during phases S1 to S4 of every device access and low otherwise. `bus_state` codes are: idle 0, S0 to S5 as 1 to 6. One phase lasts one clock.
- R3: In a normal device access, S3 repeats while `dtack` is low. The request is sampled on the clock where S3 sees `dtack` high, which is the last S3.
- R4: If the sampled request is high, the next device access begins with S0 right after S5. If it is low, no further device access starts until the controller, back in idle, sees the request high again.
- R5: A request negated after the sample point of an access lets exactly one more device access run before the burst stops.
- R6: With `req_direct`=0 the sampled request is the `dreq` value registered one clock earlier. With `req_direct`=1 it is `dreq` itself.
- R7: With `fast_term`=1, a device access skips S3 (S2 is followed by S4), and the request is sampled at S2. A negation seen there always lets one more device access run before the burst stops.
- R8: With `pack_en`=1 and `dev_src`=1, each device read stores `dev_rdata` into holding byte lane `lane` (bits 8*lane+7:8*lane), sets that valid bit and advances `lane` modulo 4. After the fourth byte, a memory write with `mem_be`=4'hF follows.
- R9: In source packing, a stop always produces one memory write whose `mem_be` equals the valid bytes, after which the valid bytes are cleared. The controller is never idle with valid bytes.
- R10: With `pack_en`=1 and `dev_src`=0, an empty holding register is loaded from `mem_rdata` by a memory read (`mem_be` becomes 4'hF). Each device write then presents byte `lane` on `dev_wdata` and clears its valid bit. A stop keeps the remaining bytes, and a resume continues at `lane` without a memory read.
- R11: A memory access is six clocks with no wait states. `mem_rd` or `mem_wr` is high during S1 to S4, and never together with `dack`.
- R12: From idle, S0 begins on the clock after the effective request is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per bus state pair (one phase per clock) |
| rst | input | 1 | Synchronous active-high reset |
| req_direct | input | 1 | 1: use request unsynchronized |
| pack_en | input | 1 | Enable byte packing through holding register |
| dev_src | input | 1 | 1: peripheral is the data source |
| fast_term | input | 1 | Device accesses terminate fast |
| dreq | input | 1 | Peripheral burst request |
| dtack | input | 1 | Device access termination in S3 |
| dev_rdata | input | 8 | Byte read from the peripheral |
| mem_rdata | input | 32 | Word read from memory |
| dack | output | 1 | Device acknowledge strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Holding register contents |
| mem_be | output | 4 | Valid bytes of holding register |
| dev_wdata | output | 8 | Byte offered to the peripheral |
| lane | output | 2 | Packing byte lane |
| bus_state | output | 3 | Current phase code |

## Verification
The assertions assume that `req_direct`, `pack_en`, `dev_src` and `fast_term` are held steady while the controller is out of reset. They also assume that `dtack` only matters in S3 of a normal device access. The stimulus sets these mode inputs only while reset is high, and every scenario starts from reset. Within that, `dreq`, `dtack` and both data buses change freely on every falling clock edge, so waits, stops and resumes land on every phase.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_S0   = 3'd1,
    PH_S1   = 3'd2,
    PH_S2   = 3'd3,
    PH_S3   = 3'd4,
    PH_S4   = 3'd5,
    PH_S5   = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    K_DEV = 2'd0,
    K_MRD = 2'd1,
    K_MWR = 2'd2
  } kind_e;

  // strobe window shared by every access type
  function automatic logic strobe_phase(phase_e p);
    return (p == PH_S1) || (p == PH_S2) || (p == PH_S3) || (p == PH_S4);
  endfunction

  // modulo increment of a lane index
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/dmab_req_sampler.sv
module dmab_req_sampler (
  input  logic clk,
  input  logic rst,
  input  logic req_direct,
  input  logic dreq,
  output logic req_eff
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= dreq;
  end

  assign req_eff = req_direct ? dreq : req_q;
endmodule

// File: rtl/dmab_seq.sv
module dmab_seq
  import dmab_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_eff,
  input  logic   dtack,
  input  logic   fast_term,
  input  logic   pack_en,
  input  logic   dev_src,
  input  logic   last_lane,
  input  logic   vld_any,
  output phase_e ph,
  output kind_e  kind,
  output logic   decide,
  output logic   decide_go,
  output logic   smp_evt,
  output logic   cyc_end
);
  phase_e ph_n;
  kind_e  kind_n;
  logic   cont, cont_n;
  logic   late, late_n;
  logic   fast_dec;

  assign smp_evt   = (kind == K_DEV) && (ph == PH_S3) && dtack;
  assign fast_dec  = (kind == K_DEV) && (ph == PH_S2) && fast_term;
  assign decide    = smp_evt | fast_dec;
  assign decide_go = fast_dec ? ~late : (req_eff & ~late);
  assign cyc_end   = (ph == PH_S5);

  always_comb begin
    ph_n   = ph;
    kind_n = kind;
    cont_n = decide ? decide_go : cont;
    late_n = decide ? (fast_dec & ~req_eff) : late;
    unique case (ph)
      PH_IDLE: begin
        if (req_eff) begin
          ph_n   = PH_S0;
          late_n = 1'b0;
          kind_n = (pack_en && !dev_src && !vld_any) ? K_MRD : K_DEV;
        end
      end
      PH_S0: ph_n = PH_S1;
      PH_S1: ph_n = PH_S2;
      PH_S2: ph_n = fast_dec ? PH_S4 : PH_S3;
      PH_S3: begin
        if (kind != K_DEV || dtack) ph_n = PH_S4;
      end
      PH_S4: ph_n = PH_S5;
      PH_S5: begin
        ph_n = PH_S0;
        unique case (kind)
          K_MRD: kind_n = K_DEV;
          K_MWR: begin
            if (cont) kind_n = K_DEV;
            else      ph_n   = PH_IDLE;
          end
          default: begin
            if (pack_en && dev_src)
              kind_n = (last_lane || !cont) ? K_MWR : K_DEV;
            else if (cont)
              kind_n = (pack_en && last_lane) ? K_MRD : K_DEV;
            else
              ph_n = PH_IDLE;
          end
        endcase
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      kind <= K_DEV;
      cont <= 1'b0;
      late <= 1'b0;
    end else begin
      ph   <= ph_n;
      kind <= kind_n;
      cont <= cont_n;
      late <= late_n;
    end
  end
endmodule

// File: rtl/dmab_pack.sv
module dmab_pack
  import dmab_pkg::*;
#(
  parameter  int BYTES = 4,
  parameter  int BW    = 8,
  localparam int LW    = $clog2(BYTES),
  localparam int WW    = BYTES * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pack_en,
  input  logic          dev_src,
  input  kind_e         kind,
  input  logic          cyc_end,
  input  logic [BW-1:0] dev_rdata,
  input  logic [WW-1:0] mem_rdata,
  output logic [WW-1:0] hold_q,
  output logic [BYTES-1:0] vld,
  output logic [LW-1:0] lane,
  output logic          last_lane,
  output logic          vld_any,
  output logic [BW-1:0] dev_byte
);
  logic end_dev, end_mrd, end_mwr;

  assign end_dev   = cyc_end && (kind == K_DEV) && pack_en;
  assign end_mrd   = cyc_end && (kind == K_MRD);
  assign end_mwr   = cyc_end && (kind == K_MWR);
  assign last_lane = (int'(lane) == BYTES - 1);
  assign vld_any   = |vld;
  assign dev_byte  = hold_q[int'(lane)*BW +: BW];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[g*BW +: BW] <= '0;
        vld[g]             <= 1'b0;
      end else if (end_mrd) begin
        hold_q[g*BW +: BW] <= mem_rdata[g*BW +: BW];
        vld[g]             <= 1'b1;
      end else if (end_mwr) begin
        vld[g] <= 1'b0;
      end else if (end_dev && int'(lane) == g) begin
        if (dev_src) begin
          hold_q[g*BW +: BW] <= dev_rdata;
          vld[g]             <= 1'b1;
        end else begin
          vld[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     lane <= '0;
    else if (end_mrd || end_mwr) lane <= '0;
    else if (end_dev)            lane <= LW'(wrap_inc(int'(lane), BYTES));
  end
endmodule

// File: rtl/dmab_burst_ctrl.sv
module dmab_burst_ctrl
  import dmab_pkg::*;
#(
  parameter  int BYTES = 4,
  parameter  int BW    = 8,
  localparam int LW    = $clog2(BYTES),
  localparam int WW    = BYTES * BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_direct,
  input  logic             pack_en,
  input  logic             dev_src,
  input  logic             fast_term,
  input  logic             dreq,
  input  logic             dtack,
  input  logic [BW-1:0]    dev_rdata,
  input  logic [WW-1:0]    mem_rdata,
  output logic             dack,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [WW-1:0]    mem_wdata,
  output logic [BYTES-1:0] mem_be,
  output logic [BW-1:0]    dev_wdata,
  output logic [LW-1:0]    lane,
  output logic [2:0]       bus_state
);
  phase_e ph;
  kind_e  kind;
  logic   req_eff, decide, decide_go, smp_evt, cyc_end;
  logic   last_lane, vld_any;

  dmab_req_sampler u_smp (
    .clk(clk), .rst(rst), .req_direct(req_direct), .dreq(dreq), .req_eff(req_eff)
  );

  dmab_seq u_seq (
    .clk(clk), .rst(rst), .req_eff(req_eff), .dtack(dtack), .fast_term(fast_term),
    .pack_en(pack_en), .dev_src(dev_src), .last_lane(last_lane), .vld_any(vld_any),
    .ph(ph), .kind(kind), .decide(decide), .decide_go(decide_go),
    .smp_evt(smp_evt), .cyc_end(cyc_end)
  );

  dmab_pack #(.BYTES(BYTES), .BW(BW)) u_pack (
    .clk(clk), .rst(rst), .pack_en(pack_en), .dev_src(dev_src), .kind(kind),
    .cyc_end(cyc_end), .dev_rdata(dev_rdata), .mem_rdata(mem_rdata),
    .hold_q(mem_wdata), .vld(mem_be), .lane(lane), .last_lane(last_lane),
    .vld_any(vld_any), .dev_byte(dev_wdata)
  );

  assign dack      = (kind == K_DEV) && strobe_phase(ph);
  assign mem_rd    = (kind == K_MRD) && strobe_phase(ph);
  assign mem_wr    = (kind == K_MWR) && strobe_phase(ph);
  assign bus_state = ph;
endmodule

// File: rtl/dmab_burst_chk.sv
module dmab_burst_chk #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             dreq,
  input logic             dtack,
  input logic             req_direct,
  input logic             pack_en,
  input logic             dev_src,
  input logic             fast_term,
  input logic             dack,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [2:0]       bus_state,
  input logic [BYTES-1:0] mem_be,
  input logic             decide,
  input logic             decide_go,
  input logic             smp_evt,
  input logic             smp_val
);
  logic stopped;

  always_ff @(posedge clk) begin
    if (rst)                        stopped <= 1'b0;
    else if (decide && !decide_go)  stopped <= 1'b1;
    else if (bus_state == 3'd0)     stopped <= 1'b0;
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dack, mem_rd, mem_wr}));

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dack && bus_state == 3'd4 && !dtack) |=> (bus_state == 3'd4));

  p_stop_no_dev_r4: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !$rose(dack));

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_evt && !req_direct) |-> (smp_val == $past(dreq)));

  p_fast_skip_r7: assert property (@(posedge clk) disable iff (rst)
    (dack && fast_term && bus_state == 3'd3) |=> (bus_state == 3'd5));

  p_wr_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr) |=> (mem_be == '0));

  p_no_idle_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_state == 3'd0 && pack_en && dev_src) |-> (mem_be == '0));

  p_rd_fill_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd) |=> (mem_be == '1));
endmodule

bind dmab_burst_ctrl dmab_burst_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst(rst), .dreq(dreq), .dtack(dtack), .req_direct(req_direct),
  .pack_en(pack_en), .dev_src(dev_src), .fast_term(fast_term), .dack(dack),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_state(bus_state), .mem_be(mem_be),
  .decide(decide), .decide_go(decide_go), .smp_evt(smp_evt), .smp_val(req_eff)
);

// File: tb/sim_dmab_burst_ctrl.sv
module sim_dmab_burst_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_direct = 1'b0, pack_en = 1'b0, dev_src = 1'b0, fast_term = 1'b0;
  logic dreq = 1'b0, dtack = 1'b1;
  logic [7:0]  dev_rdata = 8'h00;
  logic [31:0] mem_rdata = 32'h0;
  logic dack, mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [7:0]  dev_wdata;
  logic [1:0]  lane;
  logic [2:0]  bus_state;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dmab_burst_ctrl u0 (
    .clk(clk), .rst(rst), .req_direct(req_direct), .pack_en(pack_en), .dev_src(dev_src),
    .fast_term(fast_term), .dreq(dreq), .dtack(dtack), .dev_rdata(dev_rdata),
    .mem_rdata(mem_rdata), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .dev_wdata(dev_wdata), .lane(lane),
    .bus_state(bus_state)
  );

  // behavioural reference: ph -1 idle, 0..5 phases; knd 0 dev, 1 mem read, 2 mem write
  int m_ph, m_knd, m_lane;
  bit m_cont, m_late, m_sync, m_re, m_last;
  logic [31:0] m_hold;
  logic [3:0]  m_vld;

  always @(posedge clk) begin
    m_re   = req_direct ? dreq : m_sync;
    m_sync = rst ? 1'b0 : dreq;
    if (rst) begin
      m_ph = -1; m_knd = 0; m_lane = 0; m_cont = 0; m_late = 0;
      m_hold = 32'h0; m_vld = 4'h0;
    end else begin
      case (m_ph)
        -1: if (m_re) begin
              m_ph = 0; m_late = 0;
              m_knd = (pack_en && !dev_src && m_vld == 0) ? 1 : 0;
            end
        0: m_ph = 1;
        1: m_ph = 2;
        2: if (m_knd == 0 && fast_term) begin
             m_cont = !m_late; m_late = !m_re; m_ph = 4;
           end else m_ph = 3;
        3: if (m_knd != 0) m_ph = 4;
           else if (dtack) begin m_cont = m_re && !m_late; m_late = 0; m_ph = 4; end
        4: m_ph = 5;
        default: begin
          if (m_knd == 1) begin
            m_hold = mem_rdata; m_vld = 4'hF; m_lane = 0; m_knd = 0; m_ph = 0;
          end else if (m_knd == 2) begin
            m_vld = 4'h0; m_lane = 0;
            if (m_cont) begin m_knd = 0; m_ph = 0; end else m_ph = -1;
          end else begin
            m_last = (m_lane == 3);
            if (pack_en) begin
              if (dev_src) begin m_hold[m_lane*8 +: 8] = dev_rdata; m_vld[m_lane] = 1'b1; end
              else m_vld[m_lane] = 1'b0;
              m_lane = (m_lane + 1) % 4;
            end
            if (pack_en && dev_src) begin m_knd = (m_last || !m_cont) ? 2 : 0; m_ph = 0; end
            else if (m_cont) begin m_knd = (pack_en && m_last) ? 1 : 0; m_ph = 0; end
            else m_ph = -1;
          end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and event counters
  int n_dack, n_wr, n_rd;
  logic [3:0] last_be;
  bit p_dack, p_wr, p_rd;
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit e_on;
      e_on = (m_ph >= 1 && m_ph <= 4);
      chk(dack === (e_on && m_knd == 0), "R2 dack", dack, e_on && m_knd == 0);
      chk(mem_rd === (e_on && m_knd == 1), "R11 mem_rd", mem_rd, e_on && m_knd == 1);
      chk(mem_wr === (e_on && m_knd == 2), "R11 mem_wr", mem_wr, e_on && m_knd == 2);
      chk(int'(bus_state) == m_ph + 1, (m_ph == 0) ? "R12 bus_state" : "R3 bus_state",
          bus_state, m_ph + 1);
      chk(int'(lane) == m_lane, "R8 lane", lane, m_lane);
      chk(mem_be === m_vld, "R9 mem_be", mem_be, m_vld);
      if (e_on && m_knd == 0 && pack_en && !dev_src)
        chk(dev_wdata === m_hold[m_lane*8 +: 8], "R10 dev_wdata", dev_wdata, m_hold[m_lane*8 +: 8]);
      if (e_on && m_knd == 2)
        chk(mem_wdata === m_hold, "R8 mem_wdata", mem_wdata, m_hold);
    end
    if (dack && !p_dack) n_dack++;
    if (mem_wr && !p_wr) begin n_wr++; last_be = mem_be; end
    if (mem_rd && !p_rd) n_rd++;
    p_dack = dack; p_wr = mem_wr; p_rd = mem_rd;
  end

  logic [15:0] lf = 16'hACE1;
  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic do_reset(input bit dir, input bit fst, input bit pk, input bit src);
    @(negedge clk);
    rst = 1'b1; dreq = 1'b0; dtack = 1'b1;
    req_direct = dir; fast_term = fst; pack_en = pk; dev_src = src;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_dack = 0; n_wr = 0; n_rd = 0;
  endtask

  task automatic run_rand(input bit dir, input bit fst, input bit pk, input bit src, input int n);
    do_reset(dir, fst, pk, src);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_lfsr();
      dreq      = (lf[3:0] > 4'd4);
      dtack     = (lf[7:6] != 2'b00);
      dev_rdata = lf[15:8] ^ lf[7:0];
      mem_rdata = {lf, ~lf};
    end
    dreq = 1'b0; dtack = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  // raise request, drop it on the negedge where bus_state first equals tgt
  task automatic run_drop(input bit dir, input bit fst, input int tgt, input int exp, input string tag);
    do_reset(dir, fst, 1'b0, 1'b0);
    dreq = 1'b1;
    for (int i = 0; i < 20 && int'(bus_state) != tgt; i++) @(negedge clk);
    dreq = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_dack == exp, tag, n_dack, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    // R1 reset state
    chk(bus_state == 3'd0, "R1 bus_state", bus_state, 0);
    chk({dack, mem_rd, mem_wr} == 3'b000, "R1 strobes", {dack, mem_rd, mem_wr}, 0);
    chk(mem_be == 4'h0 && lane == 2'd0, "R1 holding", {mem_be, lane}, 0);

    // R4: negated before the sample edge -> one access only
    run_drop(1'b1, 1'b0, 4, 1, "R4 in-time stop");
    // R5: negated after the sample -> exactly one extra access
    run_drop(1'b1, 1'b0, 5, 2, "R5 late stop");
    // R6: synchronized path needs one clock more
    run_drop(1'b0, 1'b0, 4, 2, "R6 sync late");
    run_drop(1'b0, 1'b0, 3, 1, "R6 sync in-time");
    // R7: fast access always gives one more
    run_drop(1'b1, 1'b1, 3, 2, "R7 fast stop");

    // R9: partial source packing flushed with valid-byte enables
    do_reset(1'b1, 1'b0, 1'b1, 1'b1);
    dreq = 1'b1;
    for (int i = 0; i < 40 && !(n_dack == 2 && bus_state == 3'd4); i++) @(negedge clk);
    dreq = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_wr == 1, "R9 flush count", n_wr, 1);
    chk(last_be == 4'b0011, "R9 flush enables", last_be, 4'b0011);

    // R10: destination packing stops mid-word and keeps the rest
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    dreq = 1'b1;
    for (int i = 0; i < 60 && !(n_dack == 3 && bus_state == 3'd4); i++) @(negedge clk);
    dreq = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_rd == 1 && lane == 2'd3, "R10 paused lane", {n_rd[3:0], lane}, {4'd1, 2'd3});
    chk(mem_be == 4'b1000, "R10 kept bytes", mem_be, 4'b1000);

    // randomized runs across all modes (R2, R3, R8, R10, R11, R12 via model)
    run_rand(1'b0, 1'b0, 1'b0, 1'b0, 400);
    run_rand(1'b1, 1'b0, 1'b0, 1'b0, 400);
    run_rand(1'b0, 1'b1, 1'b0, 1'b0, 400);
    run_rand(1'b1, 1'b0, 1'b1, 1'b1, 600);
    run_rand(1'b0, 1'b1, 1'b1, 1'b1, 600);
    run_rand(1'b1, 1'b0, 1'b1, 1'b0, 600);
    run_rand(1'b0, 1'b1, 1'b1, 1'b0, 600);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule